// File: doc/BRIEF.md
# Bipolar Line Encoder with Zero Substitution

This block sits at the transmit end of a DS3 or E3 line interface. Each clock cycle it takes one bit of unipolar NRZ data and drives two output rails. The positive rail carries positive marks and the negative rail carries negative marks. Data ones become alternating marks (AMI). Long runs of zeros are replaced by substitution codes. In DS3 the code is B3ZS, with groups `00V` and `B0V`. In E3 the code is HDB3, with groups `000V` and `B00V`. A `B` is a pulse that obeys the alternation rule. A `V` is a pulse that breaks it, because it repeats the polarity of the pulse before it. The substitution group is chosen so that the number of pulses between two successive `V` pulses is always odd.

Two further modes are available. In the first, substitution is switched off and plain AMI is sent. In the second, the bipolar coding is bypassed: the NRZ data goes straight out on the positive rail and the line clock goes out on the negative rail. For test equipment, an error input can force deliberate line code violations. Each rising edge of that input produces exactly one violation. One type sends a data mark with the wrong polarity. The other type leaves out the next substitution that would have been made. All modes share one four-stage look-ahead window, so the latency does not depend on the mode.

Top module: `lc_line_encoder`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, both rails are low. Outside bypass, the two rails are never high in the same cycle.
- R2: An input bit sampled at clock edge k decides the rails from edge k+4 onward, in every mode. A zero that is not part of a substitution group produces no pulse. The four outputs after reset are zeros.
- R3: Plain AMI mode is selected with `ami_sel`=1, `test_sel`=0 and `nrz_sel`=0. In this mode every data one is a mark of polarity opposite to the previous mark. The first mark after reset is positive. Zero runs are never substituted.
- R4: B3ZS is selected with `line_hdb3`=0 and substitution on. Working from the oldest bit, each run of three zeros not yet coded is replaced. If the number of pulses since the last V is odd, the group is `00V`. If it is even, including the case with no V since reset, the group is `B0V`.
- R5: HDB3 is selected with `line_hdb3`=1 and substitution on. Each run of four zeros is replaced by `000V` when the pulse count since the last V is odd, and by `B00V` when it is even.
- R6: With `nrz_sel`=1, which takes precedence over all other controls, `tx_pos` carries the data bit with the latency of R2. From the second edge after `nrz_sel` is set, `tx_neg` follows `clk`.
- R7: With `test_sel`=0, `err_in` has no effect on the rails.
- R8: With `test_sel`=1 and `ami_sel`=0, a rising edge on `err_in` makes exactly one later data mark repeat the previous pulse polarity. Further rising edges that arrive before that mark is sent are ignored.
- R9: With `test_sel`=1 and `ami_sel`=1, a rising edge on `err_in` makes exactly one later substitution group go out as plain zeros.
- R10: With `test_sel`=1, substitution of the selected line code stays active whatever the value of `ami_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (line rate) |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 1 | Unipolar NRZ data bit, sampled each rising edge |
| line_hdb3 | input | 1 | 0 selects B3ZS (3-zero groups), 1 selects HDB3 (4-zero groups) |
| ami_sel | input | 1 | Plain AMI when test mode is off; violation type (0 polarity, 1 omitted group) when on |
| test_sel | input | 1 | Enables test-equipment violation insertion |
| nrz_sel | input | 1 | Bypass: NRZ on positive rail, clock on negative rail |
| err_in | input | 1 | Violation request, acts on its rising edge |
| tx_pos | output | 1 | Positive-mark rail |
| tx_neg | output | 1 | Negative-mark rail (clock in bypass) |

## Verification
The assertions assume that the four mode controls stay constant while the rails are being judged, and change only inside a reset. They also assume that `err_in` requests are spaced widely enough that each is consumed before the next arrives. The bench holds each configuration for a whole stream and resets between configurations. It drives random zero-heavy data against a bench reference encoder, and spaces the directed error pulses far apart. Random `err_in` toggling is applied only with test mode off.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int LOOKAHEAD = 4;
    localparam int B3ZS_RUN  = 3;
    localparam int HDB3_RUN  = 4;

    // Symbol held in the look-ahead window.
    typedef enum logic [2:0] {
        K_ZERO     = 3'd0,  // data zero, still eligible for substitution
        K_MARK     = 3'd1,  // data one
        K_SUB_LEAD = 3'd2,  // first slot of a substitution group (B or 0)
        K_SUB_V    = 3'd3,  // violation slot of a substitution group
        K_HOLD     = 3'd4   // zero that is never substituted
    } sym_kind_e;

    typedef struct packed {
        logic bypass;   // NRZ + clock output
        logic subst;    // zero substitution active
        logic hdb3;     // 4-zero groups
        logic test;     // violation insertion armed
        logic viol_t2;  // 1: omit a group, 0: wrong-polarity mark
    } enc_mode_t;

    function automatic enc_mode_t decode_mode(input logic hdb3_sel, input logic ami_bit,
                                              input logic test_bit, input logic nrz_bit);
        enc_mode_t m;
        m.bypass  = nrz_bit;
        m.test    = test_bit & ~nrz_bit;
        m.subst   = ~nrz_bit & (test_bit | ~ami_bit);
        m.hdb3    = hdb3_sel;
        m.viol_t2 = ami_bit;
        return m;
    endfunction

    function automatic int run_len(input logic hdb3_sel);
        return hdb3_sel ? HDB3_RUN : B3ZS_RUN;
    endfunction

endpackage

// File: rtl/lc_sub_window.sv
module lc_sub_window
    import lc_pkg::*;
#(
    parameter int DEPTH = LOOKAHEAD
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_in,
    input  logic      subst,
    input  logic      hdb3,
    input  logic      skip_sub,
    output sym_kind_e head,
    output logic      sub_hit
);

    sym_kind_e buf_q [DEPTH];
    sym_kind_e work  [DEPTH];
    int        run;

    assign run = run_len(hdb3);

    always_comb begin
        sub_hit = subst;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < run && buf_q[DEPTH-1-i] != K_ZERO)
                sub_hit = 1'b0;
        end
        for (int i = 0; i < DEPTH; i++)
            work[i] = buf_q[i];
        if (sub_hit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i < run) begin
                    if (skip_sub)          work[DEPTH-1-i] = K_HOLD;
                    else if (i == run - 1) work[DEPTH-1-i] = K_SUB_V;
                    else if (i == 0)       work[DEPTH-1-i] = K_SUB_LEAD;
                    else                   work[DEPTH-1-i] = K_HOLD;
                end
            end
        end
        head = work[DEPTH-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                buf_q[i] <= K_HOLD;
        end else begin
            buf_q[0] <= bit_in ? K_MARK : K_ZERO;
            for (int i = 1; i < DEPTH; i++)
                buf_q[i] <= work[i-1];
        end
    end

endmodule

// File: rtl/lc_pulse_former.sv
module lc_pulse_former
    import lc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sym_kind_e head,
    input  logic      bypass,
    input  logic      t1_pend,
    output logic      take1,
    output logic      pos_q,
    output logic      neg_q,
    output logic      byp_q
);

    logic pol_q, odd_q;      // pol_q: 1 when last pulse was positive
    logic pol_d, odd_d, p_d, n_d;

    always_comb begin
        pol_d = pol_q;
        odd_d = odd_q;
        p_d   = 1'b0;
        n_d   = 1'b0;
        take1 = 1'b0;
        if (bypass) begin
            p_d = (head == K_MARK);
        end else begin
            case (head)
                K_MARK: begin
                    odd_d = ~odd_q;
                    if (t1_pend) begin
                        take1 = 1'b1;
                        p_d   = pol_q;
                        n_d   = ~pol_q;
                    end else begin
                        pol_d = ~pol_q;
                        p_d   = ~pol_q;
                        n_d   = pol_q;
                    end
                end
                K_SUB_LEAD: begin
                    if (!odd_q) begin
                        pol_d = ~pol_q;
                        p_d   = ~pol_q;
                        n_d   = pol_q;
                    end
                end
                K_SUB_V: begin
                    p_d   = pol_q;
                    n_d   = ~pol_q;
                    odd_d = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= 1'b0;
            odd_q <= 1'b0;
            pos_q <= 1'b0;
            neg_q <= 1'b0;
            byp_q <= 1'b0;
        end else begin
            pol_q <= pol_d;
            odd_q <= odd_d;
            pos_q <= p_d;
            neg_q <= n_d;
            byp_q <= bypass;
        end
    end

    p_rails_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(pos_q && neg_q));

endmodule

// File: rtl/lc_viol_arm.sv
module lc_viol_arm (
    input  logic clk,
    input  logic rst,
    input  logic err_in,
    input  logic test_on,
    input  logic type2_sel,
    input  logic take,
    output logic t1_pend,
    output logic t2_pend
);

    logic err_q, pend_q, t2_q, rise;

    assign rise    = err_in & ~err_q;
    assign t1_pend = pend_q & ~t2_q;
    assign t2_pend = pend_q & t2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= 1'b0;
            pend_q <= 1'b0;
            t2_q   <= 1'b0;
        end else begin
            err_q  <= err_in;
            pend_q <= test_on & (pend_q ? ~take : rise);
            if (rise && !pend_q)
                t2_q <= type2_sel;
        end
    end

    p_pend_hold_r8: assert property (@(posedge clk) disable iff (rst)
        pend_q && !take && test_on |=> pend_q);

    p_single_shot_r8: assert property (@(posedge clk) disable iff (rst)
        pend_q && take |=> !pend_q);

endmodule

// File: rtl/lc_line_encoder.sv
module lc_line_encoder
    import lc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_data,
    input  logic line_hdb3,
    input  logic ami_sel,
    input  logic test_sel,
    input  logic nrz_sel,
    input  logic err_in,
    output logic tx_pos,
    output logic tx_neg
);

    enc_mode_t mode;
    sym_kind_e head;
    logic      sub_hit, take1, take2, t1_pend, t2_pend;
    logic      pos_q, neg_q, byp_q;

    assign mode  = decode_mode(line_hdb3, ami_sel, test_sel, nrz_sel);
    assign take2 = sub_hit & t2_pend;

    lc_viol_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .err_in    (err_in),
        .test_on   (mode.test),
        .type2_sel (mode.viol_t2),
        .take      (take1 | take2),
        .t1_pend   (t1_pend),
        .t2_pend   (t2_pend)
    );

    lc_sub_window #(.DEPTH(LOOKAHEAD)) u_win (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (tx_data),
        .subst    (mode.subst),
        .hdb3     (mode.hdb3),
        .skip_sub (t2_pend),
        .head     (head),
        .sub_hit  (sub_hit)
    );

    lc_pulse_former u_form (
        .clk     (clk),
        .rst     (rst),
        .head    (head),
        .bypass  (mode.bypass),
        .t1_pend (t1_pend),
        .take1   (take1),
        .pos_q   (pos_q),
        .neg_q   (neg_q),
        .byp_q   (byp_q)
    );

    assign tx_pos = pos_q;
    assign tx_neg = byp_q ? clk : neg_q;

    p_zero_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !mode.bypass && (head == K_ZERO || head == K_HOLD) |=> !tx_pos && !neg_q);

    p_bypass_data_r6: assert property (@(posedge clk) disable iff (rst)
        mode.bypass && head == K_MARK |=> tx_pos);

    p_test_off_r7: assert property (@(posedge clk) disable iff (rst)
        !mode.test |=> !t1_pend && !t2_pend);

endmodule

// File: tb/test_lc_line_encoder.sv
module test_lc_line_encoder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_data = 1'b0, line_hdb3 = 1'b0, ami_sel = 1'b0;
    logic test_sel = 1'b0, nrz_sel = 1'b0, err_in = 1'b0;
    logic tx_pos, tx_neg;

    int checks = 0;
    int errors = 0;

    bit stim [0:511];
    bit errv [0:511];
    bit ex_p [0:511];
    bit ex_n [0:511];
    bit op   [0:511];
    bit on   [0:511];

    always #5 clk = ~clk;

    lc_line_encoder i_lc_line_encoder (
        .clk(clk), .rst(rst), .tx_data(tx_data), .line_hdb3(line_hdb3),
        .ami_sel(ami_sel), .test_sel(test_sel), .nrz_sel(nrz_sel),
        .err_in(err_in), .tx_pos(tx_pos), .tx_neg(tx_neg)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic h, input logic a, input logic t, input logic z);
        @(negedge clk);
        rst = 1'b1; tx_data = 0; err_in = 0;
        line_hdb3 = h; ami_sel = a; test_sel = t; nrz_sel = z;
        repeat (3) @(negedge clk);
        check(tx_pos == 0 && tx_neg == 0, "R1 reset rails", {tx_pos, tx_neg}, 0);
        rst = 1'b0;
    endtask

    task automatic clear_stim(input int n);
        for (int i = 0; i < 512; i++) begin
            stim[i] = 0;
            errv[i] = 0;
        end
        for (int i = 0; i < n; i++) stim[i] = ($urandom % 5) < 2;
    endtask

    task automatic run_stream(input int n);
        for (int c = 0; c < n + 8; c++) begin
            tx_data = stim[c];
            err_in  = errv[c];
            @(negedge clk);
            op[c] = tx_pos;
            on[c] = tx_neg;
        end
        tx_data = 0;
        err_in  = 0;
    endtask

    // Reference encoder: greedy substitution from the oldest bit.
    task automatic model(input int n, input bit sub, input bit hdb3);
        int  k;
        bit  pol;
        bit  odd;
        bit  allz;
        int  i;
        k = hdb3 ? 4 : 3;
        pol = 0;
        odd = 0;
        for (int j = 0; j < 512; j++) begin ex_p[j] = 0; ex_n[j] = 0; end
        i = 0;
        while (i < n + 8) begin
            allz = sub && (i + k <= n + 8);
            for (int j = 0; j < k; j++)
                if (allz && stim[i+j]) allz = 0;
            if (allz) begin
                if (!odd) begin
                    pol = ~pol;
                    ex_p[i] = pol; ex_n[i] = ~pol;
                end
                ex_p[i+k-1] = pol; ex_n[i+k-1] = ~pol;
                odd = 0;
                i += k;
            end else begin
                if (stim[i]) begin
                    pol = ~pol;
                    odd = ~odd;
                    ex_p[i] = pol; ex_n[i] = ~pol;
                end
                i++;
            end
        end
    endtask

    task automatic compare(input int n, input string tag);
        for (int c = 0; c < n + 4; c++) begin
            bit ep, en;
            ep = (c < 4) ? 1'b0 : ex_p[c-4];
            en = (c < 4) ? 1'b0 : ex_n[c-4];
            check(op[c] == ep && on[c] == en, tag, {op[c], on[c]}, {ep, en});
        end
    endtask

    function automatic int count_pulses(input int lo, input int hi);
        int s = 0;
        for (int c = lo; c <= hi; c++) s += op[c] + on[c];
        return s;
    endfunction

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int same;
        bit lastp;
        bit seen;
        void'($urandom(32'd4711));

        // R2 R3: directed latency and alternation in plain AMI
        do_reset(0, 1, 0, 0);
        clear_stim(0);
        n = 12;
        stim[0] = 1; stim[1] = 1; stim[5] = 1;
        run_stream(n);
        check(op[4] == 1 && on[4] == 0, "R2 latency first mark", {op[4], on[4]}, 2);
        check(op[3] == 0 && on[3] == 0, "R2 quiet before latency", {op[3], on[3]}, 0);
        check(op[5] == 0 && on[5] == 1, "R3 alternation", {op[5], on[5]}, 1);

        // R3: random AMI, no substitution
        do_reset(1, 1, 0, 0);
        n = 120; clear_stim(n);
        run_stream(n); model(n, 0, 1); compare(n, "R3 AMI stream");

        // R4: directed B3ZS parity cases (even -> B0V, odd -> 00V)
        do_reset(0, 0, 0, 0);
        clear_stim(0);
        n = 20;
        stim[0] = 1; stim[4] = 1; stim[5] = 1; stim[9] = 1;
        run_stream(n); model(n, 1, 0); compare(n, "R4 B3ZS directed");

        // R4: random B3ZS
        do_reset(0, 0, 0, 0);
        n = 200; clear_stim(n);
        run_stream(n); model(n, 1, 0); compare(n, "R4 B3ZS stream");

        // R5: random HDB3
        do_reset(1, 0, 0, 0);
        n = 200; clear_stim(n);
        run_stream(n); model(n, 1, 1); compare(n, "R5 HDB3 stream");

        // R6: bypass, data on positive rail, clock on negative rail
        do_reset(1, 0, 1, 1);
        n = 60; clear_stim(n);
        run_stream(n);
        for (int c = 4; c < n + 4; c++)
            check(op[c] == stim[c-4] && on[c] == 0, "R6 bypass data", {op[c], on[c]}, {stim[c-4], 1'b0});
        @(posedge clk); #1;
        check(tx_neg == 1, "R6 clock high phase", tx_neg, 1);
        @(negedge clk); #1;
        check(tx_neg == 0, "R6 clock low phase", tx_neg, 0);

        // R7: error input ignored with test mode off
        do_reset(1, 0, 0, 0);
        n = 150; clear_stim(n);
        for (int i = 0; i < n; i++) errv[i] = ($urandom % 4) == 0;
        run_stream(n); model(n, 1, 1); compare(n, "R7 err ignored");

        // R10: test mode with ami_sel=1 still substitutes
        do_reset(0, 1, 1, 0);
        n = 150; clear_stim(n);
        run_stream(n); model(n, 1, 0); compare(n, "R10 subst in test");

        // R8: polarity violations on an all-ones stream, two requests
        do_reset(0, 0, 1, 0);
        clear_stim(0);
        n = 60;
        for (int i = 0; i < n; i++) stim[i] = 1;
        errv[10] = 1; errv[11] = 1; errv[30] = 1;
        run_stream(n);
        same = 0; seen = 0; lastp = 0;
        for (int c = 4; c < n + 4; c++) begin
            if (op[c] || on[c]) begin
                if (seen && lastp == op[c]) same++;
                lastp = op[c];
                seen = 1;
            end
        end
        check(same == 2, "R8 violation count", same, 2);
        check(count_pulses(4, n + 3) == n, "R8 marks kept", count_pulses(4, n + 3), n);

        // R9: omitted HDB3 group on an all-zero stream
        do_reset(1, 1, 1, 0);
        clear_stim(0);
        n = 64;
        errv[20] = 1;
        run_stream(n); model(n, 1, 1);
        begin
            int base = 0;
            for (int c = 0; c < n; c++) base += ex_p[c] + ex_n[c];
            check(count_pulses(4, n + 3) == base - 2, "R9 group omitted",
                  count_pulses(4, n + 3), base - 2);
        end
        check(count_pulses(4, 23) == 10, "R9 groups before request", count_pulses(4, 23), 10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule